// File: doc/BRIEF.md
# Receive-Level and Clear-to-Send Flow Control

This block provides request-to-send / clear-to-send handshaking for a serial port. On the receive side it compares the receive FIFO fill level with a high-water mark chosen by a 2-bit code. It drops the request-to-send output when the FIFO nears full, and raises it again only once the level has drained four bytes below that mark.

On the transmit side it synchronises the incoming clear-to-send line and decides whether the serialiser may start a new frame. That decision changes only in cycles where the transmitter reports a frame boundary, so a frame that has already started always runs to completion.

Each direction has its own enable bit and polarity-invert bit in the control word. A break bit in the same word forces the transmit line low whatever the flow-control state is. The FIFOs and the serialiser sit outside the block.

Top module: `flowctl_top`

## Requirements
- R1: The high-water mark is taken from control bits 20:19: code 0 gives 8 bytes, 1 gives 16, 2 gives 32 and 3 gives 48.
- R2: With control bit 18 set, a receive level at or above the mark, sampled at a clock edge, deasserts request-to-send from that edge on.
- R3: Once deasserted, request-to-send stays deasserted while the level is at or above (mark − 4). It reasserts at the first edge that samples a level below (mark − 4).
- R4: The request-to-send pin carries the internal "ready" value XOR control bit 21. With bit 21 clear, a high pin means ready to receive.
- R5: With control bit 18 clear, request-to-send is held asserted: the pin equals the inverse of bit 21.
- R6: The clear-to-send input passes through two synchronising flops. With the frame boundary held high, a change on the input reaches the transmit permit at the third rising edge after it.
- R7: The transmit permit changes only at edges where the frame-boundary input is high. In any other cycle it keeps its value, so a frame in progress is never cut.
- R8: Control bit 15 inverts clear-to-send. With bit 15 clear, a high input means clear to send. With it set, a low input means clear to send.
- R9: With control bit 14 clear, the transmit permit is high at all times.
- R10: With control bit 8 set, the transmit line is low whatever the serialiser drives and whatever the flow-control state. With bit 8 clear, the line follows the serialiser output.
- R11: After reset, request-to-send is asserted, and the transmit permit is low while clear-to-send gating is enabled, until the first frame boundary samples a clear input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Control word holding the flow-control and break fields |
| rx_level | input | LVL_W | Receive FIFO fill level in bytes |
| cts_in | input | 1 | Raw clear-to-send input (asynchronous) |
| frame_boundary | input | 1 | High while the transmitter is between frames |
| tx_serial | input | 1 | Serialiser output bit |
| rts_out | output | 1 | Request-to-send pin |
| tx_permit | output | 1 | Permission to start the next frame |
| tx_line | output | 1 | Transmit line after break forcing |

## Verification
The bench builds the block with LVL_W = 7, so levels up to 127 can be driven. That covers all four marks, including the 48-byte one, the bands just below and above each mark, and levels well beyond the largest mark. The random stimulus centres the level on the active mark, with a spread of ±8, so the hysteresis band (mark − 4 up to mark − 1) is entered from both sides many times. The control word, the clear-to-send input and the frame boundary are toggled at random as well. Directed sequences pin down the three-edge synchroniser latency, the freezing of the permit between boundaries, and break forcing while flow control holds.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  localparam int unsigned HYST        = 4;
  localparam int unsigned BIT_BREAK   = 8;
  localparam int unsigned BIT_CTS_EN  = 14;
  localparam int unsigned BIT_CTS_INV = 15;
  localparam int unsigned BIT_RTS_EN  = 18;
  localparam int unsigned BIT_MARK_LO = 19;
  localparam int unsigned BIT_RTS_INV = 21;

  // High-water mark in bytes for a 2-bit code: 8, 16, 32, 48
  function automatic int unsigned high_mark(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int unsigned low_mark(input logic [1:0] code);
    return high_mark(code) - HYST;
  endfunction
endpackage

// File: rtl/flowctl_cts_sync.sv
module flowctl_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/flowctl_rts_gen.sv
module flowctl_rts_gen
  import flowctl_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       mark_code,
  output logic             full_hold
);
  logic [LVL_W-1:0] hi_m, lo_m;
  logic             hold_q;
  logic             above_hi, below_lo;

  assign hi_m     = LVL_W'(high_mark(mark_code));
  assign lo_m     = LVL_W'(low_mark(mark_code));
  assign above_hi = (rx_level >= hi_m);
  assign below_lo = (rx_level < lo_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= 1'b0;
    else if (above_hi) hold_q <= 1'b1;
    else if (below_lo) hold_q <= 1'b0;
  end

  assign full_hold = hold_q;

  p_hold_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= hi_m) |=> full_hold);
  p_hold_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level < lo_m) |=> !full_hold);
  p_hold_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_level < hi_m) && (rx_level >= lo_m)) |=> $stable(full_hold));
endmodule

// File: rtl/flowctl_tx_gate.sv
module flowctl_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_now,
  input  logic frame_boundary,
  output logic permit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              permit_q <= 1'b0;
    else if (frame_boundary) permit_q <= clear_now;
  end

  p_permit_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_boundary |=> $stable(permit_q));
  p_permit_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_boundary |=> (permit_q == $past(clear_now)));
endmodule

// File: rtl/flowctl_top.sv
module flowctl_top
  import flowctl_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ctrl_word,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             cts_in,
  input  logic             frame_boundary,
  input  logic             tx_serial,
  output logic             rts_out,
  output logic             tx_permit,
  output logic             tx_line
);
  logic rts_en, rts_inv, cts_en, cts_inv, brk;
  logic [1:0] mark_code;
  logic full_hold, rts_ready, cts_synced, cts_clear, permit_q;
  logic ctrl_unused;

  assign rts_en    = ctrl_word[BIT_RTS_EN];
  assign rts_inv   = ctrl_word[BIT_RTS_INV];
  assign cts_en    = ctrl_word[BIT_CTS_EN];
  assign cts_inv   = ctrl_word[BIT_CTS_INV];
  assign brk       = ctrl_word[BIT_BREAK];
  assign mark_code = ctrl_word[BIT_MARK_LO +: 2];
  assign ctrl_unused = ^{ctrl_word[31:22], ctrl_word[17:16],
                         ctrl_word[13:9], ctrl_word[7:0]};

  flowctl_rts_gen #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level),
    .mark_code(mark_code), .full_hold(full_hold));

  flowctl_cts_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cts_in), .sync_out(cts_synced));

  // Clear to send after polarity; always clear when gating is off
  assign cts_clear = cts_en ? (cts_synced ^ cts_inv) : 1'b1;

  flowctl_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .clear_now(cts_clear),
    .frame_boundary(frame_boundary), .permit_q(permit_q));

  assign rts_ready = rts_en ? !full_hold : 1'b1;
  assign rts_out   = rts_ready ^ rts_inv;
  assign tx_permit = !cts_en || permit_q;
  assign tx_line   = brk ? 1'b0 : tx_serial;

  p_rts_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_en |-> (rts_out == !rts_inv));
  p_no_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_en |-> tx_permit);
  p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !tx_line);
  p_hold_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && full_hold) |-> (rts_out == rts_inv));
endmodule

// File: tb/tb_flowctl_top.sv
`timescale 1ns/1ps
module tb_flowctl_top;
  localparam int LVL_W = 7;
  logic clk = 0, rst_n = 0;
  logic [31:0] ctrl_word = '0;
  logic [LVL_W-1:0] rx_level = '0;
  logic cts_in = 0, frame_boundary = 0, tx_serial = 1;
  logic rts_out, tx_permit, tx_line;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flowctl_top #(.LVL_W(LVL_W)) dut (.*);

  // Bench reference state
  bit m_hold, m_s1, m_s2, m_perm;

  function automatic int mark_of(input logic [1:0] c);
    int t [4] = '{8, 16, 32, 48};
    return t[c];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 0; m_s1 = 0; m_s2 = 0; m_perm = 0;
    end else begin
      bit clr;
      int mk;
      clr = ctrl_word[14] ? (m_s2 ^ ctrl_word[15]) : 1'b1;
      if (frame_boundary) m_perm = clr;
      m_s2 = m_s1; m_s1 = cts_in;
      mk = mark_of(ctrl_word[20:19]);
      if (int'(rx_level) >= mk) m_hold = 1;
      else if (int'(rx_level) < mk - 4) m_hold = 0;
    end
  end

  function automatic bit exp_rts();
    return (ctrl_word[18] ? !m_hold : 1'b1) ^ ctrl_word[21];
  endfunction
  function automatic bit exp_permit();
    return !ctrl_word[14] || m_perm;
  endfunction
  function automatic bit exp_line();
    return ctrl_word[8] ? 1'b0 : tx_serial;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " rts R2 R3 R4 R5"}, rts_out, exp_rts());
    chk({tag, " permit R7 R8 R9"}, tx_permit, exp_permit());
    chk({tag, " line R10"}, tx_line, exp_line());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240607);
    ctrl_word = 32'h0004_4000; // rts_en, cts_en
    repeat (3) @(negedge clk);
    chk("R11 reset rts", rts_out, 1'b1);
    chk("R11 reset permit", tx_permit, 1'b0);
    rst_n = 1;
    step();

    // R1 / R2 / R3: each mark, approach and drain
    for (int c = 0; c < 4; c++) begin
      int mk;
      mk = mark_of(2'(c));
      ctrl_word = 32'h0004_0000 | (32'(c) << 19);
      rx_level = LVL_W'(mk - 1); step();
      chk("R1 below mark rts", rts_out, 1'b1);
      rx_level = LVL_W'(mk); step();
      chk("R1 R2 at mark rts", rts_out, 1'b0);
      rx_level = LVL_W'(mk - 4); step();
      chk("R3 band keeps rts low", rts_out, 1'b0);
      rx_level = LVL_W'(mk - 5); step();
      chk("R3 below band rts", rts_out, 1'b1);
    end

    // R4 inversion, R5 disabled
    ctrl_word = 32'h0024_0000; rx_level = 7'd60; step();
    chk("R4 inverted held rts", rts_out, 1'b1);
    ctrl_word = 32'h0020_0000; step();
    chk("R5 disabled inverted rts", rts_out, 1'b0);
    ctrl_word = 32'h0000_0000; step();
    chk("R5 disabled rts", rts_out, 1'b1);
    rx_level = '0; step();

    // R6 latency with boundary high
    ctrl_word = 32'h0000_4000; frame_boundary = 1; cts_in = 0;
    repeat (4) step();
    chk("R6 permit low", tx_permit, 1'b0);
    cts_in = 1;
    step(); chk("R6 edge1", tx_permit, 1'b0);
    step(); chk("R6 edge2", tx_permit, 1'b0);
    step(); chk("R6 edge3", tx_permit, 1'b1);

    // R7 frozen without boundary
    frame_boundary = 0; cts_in = 0;
    repeat (5) step();
    chk("R7 frozen permit", tx_permit, 1'b1);
    frame_boundary = 1; step();
    chk("R7 boundary takes", tx_permit, 1'b0);

    // R8 inversion: low input means clear
    ctrl_word = 32'h0000_C000; step();
    chk("R8 inverted permit", tx_permit, 1'b1);
    // R9 disabled
    ctrl_word = 32'h0000_0000; cts_in = 0; frame_boundary = 0; step();
    chk("R9 disabled permit", tx_permit, 1'b1);

    // R10 break overrides
    ctrl_word = 32'h0004_4100; tx_serial = 1; step();
    chk("R10 break line", tx_line, 1'b0);
    ctrl_word = 32'h0004_4000; step();
    chk("R10 no break line", tx_line, 1'b1);
    tx_serial = 0; step();
    chk("R10 follows serial", tx_line, 1'b0);

    // Random phase against the bench reference
    for (int i = 0; i < 3000; i++) begin
      chk_all("random");
      if ($urandom % 16 == 0) begin
        logic [31:0] w;
        w = $urandom;
        ctrl_word = w & 32'h003C_C100;
      end
      rx_level = LVL_W'(mark_of(ctrl_word[20:19]) + int'($urandom % 17) - 8);
      cts_in = 1'($urandom);
      frame_boundary = ($urandom % 4 == 0);
      tx_serial = 1'($urandom);
      step();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule